// File: doc/BRIEF.md
# Boot VID Sequencer with Serial Hand-off

This block sequences the voltage-identification targets of three internal DACs in a multi-phase regulator controller. While the enable input is low, every DAC code is held at zero. After enable rises and the reference reports good, the block captures a 2-bit boot selection, a plane strap and a debug strap from input pins. It then ramps every DAC code from zero to the boot level one code step at a time. Boot levels come from a computed 4-entry table.

Once the ramp completes, the block waits for the system power-good input. When that input is high, control passes to a serial VID interface. That interface is decoded elsewhere and arrives here as a parallel set-VID word with a per-DAC mask and a valid strobe. When power-good falls, every DAC slews back to the stored boot level and serial words are discarded until power-good returns. If the debug strap was captured high, the block enters a pin-debug state after the return, in which the two pins act as a live 2-bit VID for all DACs.

States (3-bit encoding on `seq_state`): ST_OFF=0, ST_REF_WAIT=1, ST_RAMP=2, ST_BOOT_HOLD=3, ST_SERIAL=4, ST_RETURN=5, ST_PIN_DEBUG=6. Transitions:
- OFF→REF_WAIT on enable.
- REF_WAIT→RAMP on ref_ok.
- RAMP→BOOT_HOLD when every DAC is at target.
- BOOT_HOLD→SERIAL on power-good high.
- BOOT_HOLD→PIN_DEBUG on power-good low with debug strap.
- SERIAL→RETURN on power-good low.
- RETURN→BOOT_HOLD when every DAC is at target.
- PIN_DEBUG→SERIAL on power-good high with every DAC at target.
- Any state→OFF when enable is low.

Top module: `vidseq_top`

## Requirements
- R1: While `run_en` is low, after the next rising clock edge `seq_state` is 0 (ST_OFF), every DAC code is 0 and `slew_busy` is low; the same holds after reset.
- R2: At the edge where the state is ST_REF_WAIT (1) and `ref_ok` is high, `vid_pin`, `plane_strap` and `dbg_strap` are captured; `boot_vid_q` and `plane_strap_q` show the captured values and do not follow later pin changes.
- R3: The level for a 2-bit selection s is BOOT_BASE + s*BOOT_STEP (20, 30, 40, 50 with defaults).
- R4: Each DAC code moves by at most one per cycle; a distance of d codes takes exactly d*SLEW_DIV cycles of `slew_busy` high; `slew_busy` is high exactly while some code differs from its target.
- R5: After capture, the state is ST_RAMP (2) and all codes climb from 0 to the boot level; then the state becomes ST_BOOT_HOLD (3).
- R6: ST_SERIAL (4) is entered only from ST_BOOT_HOLD or ST_PIN_DEBUG, with `sys_pgood` high and all codes at target.
- R7: In ST_SERIAL with `sys_pgood` high, `svid_valid` loads `svid_code` as the target of each DAC i whose `svid_mask[i]` is set; DAC i is `dac_code[i*CODE_W +: CODE_W]`; the code may be above or below the boot level.
- R8: In ST_SERIAL, `sys_pgood` low moves the state to ST_RETURN (5) with all targets set to the boot level; once they are reached, the state becomes ST_BOOT_HOLD.
- R9: A set-VID word strobed while not accepted (any state other than ST_SERIAL, or `sys_pgood` low, including the cycle it falls) changes no code and is not kept for later.
- R10: With the debug strap captured high, ST_BOOT_HOLD with `sys_pgood` low moves to ST_PIN_DEBUG (6), where all targets follow the level of the live `vid_pin` value.
- R11: With the debug strap captured low, `vid_pin` changes after capture do not move any code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Enable; low forces shutdown |
| ref_ok | input | 1 | Reference has reached its good threshold |
| vid_pin | input | 2 | Boot selection pins; live VID in pin-debug |
| plane_strap | input | 1 | Plane strap level, captured with boot selection |
| dbg_strap | input | 1 | Debug strap level, captured with boot selection |
| sys_pgood | input | 1 | System power-good input |
| svid_valid | input | 1 | Set-VID word strobe |
| svid_mask | input | NUM_DAC | DAC select mask for the set-VID word |
| svid_code | input | CODE_W | Requested DAC code |
| dac_code | output | NUM_DAC*CODE_W | Current DAC codes, DAC 0 in the low bits |
| slew_busy | output | 1 | Some DAC code differs from its target |
| seq_state | output | 3 | Current sequencer state |
| boot_vid_q | output | 2 | Captured boot selection |
| plane_strap_q | output | 1 | Captured plane strap |

## Verification
A set-VID strobe and the fall of power-good can land in the same cycle. Acceptance requires both the serial state and a high power-good level, so the fall must win. The bench drives the strobe, requesting a far code on every DAC, at the same clock edge that power-good drops. This is done for every boot selection and both strap modes. The run is judged by the state reaching ST_RETURN on the next edge and every DAC settling at the boot level rather than the requested code.

// File: rtl/vidseq_pkg.sv
package vidseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_REF_WAIT  = 3'd1,
        ST_RAMP      = 3'd2,
        ST_BOOT_HOLD = 3'd3,
        ST_SERIAL    = 3'd4,
        ST_RETURN    = 3'd5,
        ST_PIN_DEBUG = 3'd6
    } seq_state_e;

    // Level for a 2-bit selection: linear table computed from base and step.
    function automatic int sel_level(int base, int step, logic [1:0] sel);
        return base + int'(sel) * step;
    endfunction

endpackage

// File: rtl/vidseq_slew_chan.sv
module vidseq_slew_chan #(
    parameter int CODE_W   = 7,
    parameter int SLEW_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [CODE_W-1:0] tgt_i,
    output logic [CODE_W-1:0] code_o,
    output logic              at_tgt_o
);

    localparam int CNT_W = (SLEW_DIV > 1) ? $clog2(SLEW_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLEW_DIV - 1);

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            cnt_q  <= '0;
        end else if (clr_i) begin
            code_q <= '0;
            cnt_q  <= '0;
        end else if (code_q == tgt_i) begin
            cnt_q  <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            code_q <= (tgt_i > code_q) ? code_q + 1'b1 : code_q - 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign code_o   = code_q;
    assign at_tgt_o = (code_q == tgt_i);

    // R4: a code never jumps by more than one step outside of a clear
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (code_q == $past(code_q) ||
                    code_q == $past(code_q) + 1'b1 ||
                    code_q == $past(code_q) - 1'b1));

    // R4: a code sitting at its target stays put on the next edge
    assert_hold_at_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && code_q == tgt_i) |=> $stable(code_q));

endmodule

// File: rtl/vidseq_fsm.sv
module vidseq_fsm
    import vidseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       ref_ok,
    input  logic       sys_pgood,
    input  logic       dbg_q,
    input  logic       all_at_i,
    output seq_state_e state_o,
    output logic       clr_o,
    output logic       latch_o,
    output logic       load_boot_o,
    output logic       load_pins_o,
    output logic       accept_o
);

    seq_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:       state_d = ST_REF_WAIT;
                ST_REF_WAIT:  if (ref_ok) state_d = ST_RAMP;
                ST_RAMP:      if (all_at_i) state_d = ST_BOOT_HOLD;
                ST_BOOT_HOLD: begin
                    if (sys_pgood)  state_d = ST_SERIAL;
                    else if (dbg_q) state_d = ST_PIN_DEBUG;
                end
                ST_SERIAL:    if (!sys_pgood) state_d = ST_RETURN;
                ST_RETURN:    if (all_at_i) state_d = ST_BOOT_HOLD;
                ST_PIN_DEBUG: if (sys_pgood && all_at_i) state_d = ST_SERIAL;
                default:      state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        clr_o       = 1'b0;
        latch_o     = 1'b0;
        load_boot_o = 1'b0;
        load_pins_o = 1'b0;
        accept_o    = 1'b0;
        if (!run_en) begin
            clr_o = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF:       clr_o = 1'b1;
                ST_REF_WAIT: begin
                    latch_o     = ref_ok;
                    load_boot_o = ref_ok;
                end
                ST_SERIAL: begin
                    accept_o    = sys_pgood;
                    load_boot_o = !sys_pgood;
                end
                ST_PIN_DEBUG: load_pins_o = 1'b1;
                default: ;
            endcase
        end
    end

    assign state_o = state_q;

    // R1: enable low always lands in the off state
    assert_off_on_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> state_q == ST_OFF);

    // R6: serial mode is only entered from a settled hold or pin-debug state with power-good high
    assert_serial_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SERIAL && run_en && sys_pgood && all_at_i &&
         (state_q == ST_BOOT_HOLD || state_q == ST_PIN_DEBUG)) |=> state_q == ST_SERIAL);
    assert_serial_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SERIAL && !(sys_pgood && all_at_i)) |=> state_q != ST_SERIAL);

    // R8: power-good falling in serial mode starts the return to boot
    assert_fall_returns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state_q == ST_SERIAL && !sys_pgood) |=> state_q == ST_RETURN);

    // R10: pin-debug is only reachable with the debug strap captured high
    assert_pin_debug_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PIN_DEBUG && !dbg_q) |=> state_q != ST_PIN_DEBUG);

endmodule

// File: rtl/vidseq_top.sv
module vidseq_top
    import vidseq_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int NUM_DAC   = 3,
    parameter int SLEW_DIV  = 4,
    parameter int BOOT_BASE = 20,
    parameter int BOOT_STEP = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_en,
    input  logic                      ref_ok,
    input  logic [1:0]                vid_pin,
    input  logic                      plane_strap,
    input  logic                      dbg_strap,
    input  logic                      sys_pgood,
    input  logic                      svid_valid,
    input  logic [NUM_DAC-1:0]        svid_mask,
    input  logic [CODE_W-1:0]         svid_code,
    output logic [NUM_DAC*CODE_W-1:0] dac_code,
    output logic                      slew_busy,
    output logic [2:0]                seq_state,
    output logic [1:0]                boot_vid_q,
    output logic                      plane_strap_q
);

    seq_state_e        state;
    logic              clr, latch, load_boot, load_pins, accept;
    logic [1:0]        boot_q;
    logic              strap_q, dbg_q;
    logic [NUM_DAC-1:0] at_tgt;
    logic              all_at;
    logic [CODE_W-1:0] boot_lvl, pin_lvl;

    // Strap capture at the reference-good edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_q  <= '0;
            strap_q <= 1'b0;
            dbg_q   <= 1'b0;
        end else if (latch) begin
            boot_q  <= vid_pin;
            strap_q <= plane_strap;
            dbg_q   <= dbg_strap;
        end
    end

    // On the capture edge the registered selection is not yet valid, so use the pins
    assign boot_lvl = CODE_W'(sel_level(BOOT_BASE, BOOT_STEP, latch ? vid_pin : boot_q));
    assign pin_lvl  = CODE_W'(sel_level(BOOT_BASE, BOOT_STEP, vid_pin));
    assign all_at   = &at_tgt;

    vidseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .ref_ok     (ref_ok),
        .sys_pgood  (sys_pgood),
        .dbg_q      (dbg_q),
        .all_at_i   (all_at),
        .state_o    (state),
        .clr_o      (clr),
        .latch_o    (latch),
        .load_boot_o(load_boot),
        .load_pins_o(load_pins),
        .accept_o   (accept)
    );

    generate
        for (genvar i = 0; i < NUM_DAC; i++) begin : g_dac
            logic [CODE_W-1:0] tgt_q;
            logic [CODE_W-1:0] code;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                   tgt_q <= '0;
                else if (clr)                                 tgt_q <= '0;
                else if (load_boot)                           tgt_q <= boot_lvl;
                else if (load_pins)                           tgt_q <= pin_lvl;
                else if (accept && svid_valid && svid_mask[i]) tgt_q <= svid_code;
            end

            vidseq_slew_chan #(
                .CODE_W  (CODE_W),
                .SLEW_DIV(SLEW_DIV)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (clr),
                .tgt_i   (tgt_q),
                .code_o  (code),
                .at_tgt_o(at_tgt[i])
            );

            assign dac_code[i*CODE_W +: CODE_W] = code;

            // R9: a word strobed outside acceptance leaves this target alone unless a mode load happens
            assert_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (svid_valid && run_en && state != ST_SERIAL && state != ST_REF_WAIT &&
                 state != ST_PIN_DEBUG) |=> $stable(tgt_q));
        end
    endgenerate

    assign slew_busy     = !all_at;
    assign seq_state     = state;
    assign boot_vid_q    = boot_q;
    assign plane_strap_q = strap_q;

    // R5: the ramp state never shows a code above its boot level
    assert_ramp_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP) |-> (dac_code[CODE_W-1:0] <= boot_lvl));

endmodule

// File: tb/sim_vidseq_top.sv
`timescale 1ns/1ps
module sim_vidseq_top;

    localparam int W    = 7;
    localparam int N    = 3;
    localparam int DIV  = 2;
    localparam int BASE = 20;
    localparam int STEP = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n, run_en, ref_ok, plane_strap, dbg_strap, sys_pgood, svid_valid;
    logic [1:0]     vid_pin;
    logic [N-1:0]   svid_mask;
    logic [W-1:0]   svid_code;
    logic [N*W-1:0] dac_code;
    logic           slew_busy, plane_strap_q;
    logic [2:0]     seq_state;
    logic [1:0]     boot_vid_q;

    vidseq_top #(.CODE_W(W), .NUM_DAC(N), .SLEW_DIV(DIV), .BOOT_BASE(BASE), .BOOT_STEP(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ref_ok(ref_ok), .vid_pin(vid_pin),
        .plane_strap(plane_strap), .dbg_strap(dbg_strap), .sys_pgood(sys_pgood),
        .svid_valid(svid_valid), .svid_mask(svid_mask), .svid_code(svid_code),
        .dac_code(dac_code), .slew_busy(slew_busy), .seq_state(seq_state),
        .boot_vid_q(boot_vid_q), .plane_strap_q(plane_strap_q)
    );

    int checks = 0;
    int errs   = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lvl(int s);
        return BASE + s * STEP;
    endfunction

    function automatic int code_of(int ch);
        return int'(dac_code[ch*W +: W]);
    endfunction

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts samples with busy high, starting at the current sample
    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (slew_busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic chk_all(string req, string what, int exp);
        for (int ch = 0; ch < N; ch++) chk(code_of(ch) == exp, req, what, code_of(ch), exp);
    endtask

    task automatic send_svid(logic [N-1:0] m, int c);
        svid_valid = 1'b1;
        svid_mask  = m;
        svid_code  = W'(c);
        @(negedge clk);
        svid_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL R1 watchdog expired: got %0d cycles expected fewer", 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        int cyc, b, x, v2;
        rst_n = 1'b0; run_en = 1'b0; ref_ok = 1'b0; vid_pin = 2'd0; plane_strap = 1'b0;
        dbg_strap = 1'b0; sys_pgood = 1'b0; svid_valid = 1'b0; svid_mask = '0; svid_code = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk(seq_state == 3'd0, "R1", "reset state", seq_state, 0);
        chk_all("R1", "reset code", 0);
        chk(slew_busy == 1'b0, "R1", "reset busy", slew_busy, 0);

        for (int dbg = 0; dbg < 2; dbg++) begin
            for (int v = 0; v < 4; v++) begin
                b = lvl(v);
                run_en = 1'b1;
                tick(1);
                chk(seq_state == 3'd1, "R2", "ref wait state", seq_state, 1);
                vid_pin = 2'(v); plane_strap = 1'(v ^ dbg); dbg_strap = 1'(dbg); ref_ok = 1'b1;
                tick(1);
                chk(seq_state == 3'd2, "R5", "ramp state", seq_state, 2);
                wait_idle(cyc);
                chk(cyc == b * DIV, "R4", "soft-start cycles", cyc, b * DIV);
                chk_all("R3", "boot level", b);
                chk(boot_vid_q == 2'(v), "R2", "boot capture", boot_vid_q, v);
                chk(plane_strap_q == 1'(v ^ dbg), "R2", "strap capture", plane_strap_q, v ^ dbg);
                tick(3);
                chk(seq_state == (dbg ? 3'd6 : 3'd3), "R10", "post-ramp state", seq_state, dbg ? 6 : 3);
                plane_strap = ~plane_strap;
                v2 = (v + 1) % 4;
                vid_pin = 2'(v2);
                if (dbg == 0) begin
                    tick(6);
                    chk_all("R11", "pins ignored in hold", b);
                    chk(boot_vid_q == 2'(v), "R2", "boot held", boot_vid_q, v);
                end else begin
                    tick(1);
                    wait_idle(cyc);
                    chk(cyc == absd(lvl(v2), b) * DIV, "R10", "debug slew cycles", cyc, absd(lvl(v2), b) * DIV);
                    chk_all("R10", "debug live level", lvl(v2));
                end
                chk(plane_strap_q == 1'(v ^ dbg), "R2", "strap held", plane_strap_q, v ^ dbg);

                // Enter serial mode
                sys_pgood = 1'b1;
                tick(1);
                chk(seq_state == 3'd4, "R6", "serial entry", seq_state, 4);
                vid_pin = 2'(v);
                x = (v % 2 == 1) ? 5 : 90;
                send_svid(3'b101, x);
                wait_idle(cyc);
                chk(cyc == absd(x, (dbg ? lvl(v2) : b)) * DIV, "R7", "set-VID slew cycles",
                    cyc, absd(x, (dbg ? lvl(v2) : b)) * DIV);
                chk(code_of(0) == x, "R7", "dac0 set", code_of(0), x);
                chk(code_of(2) == x, "R7", "dac2 set", code_of(2), x);
                chk(code_of(1) == (dbg ? lvl(v2) : b), "R7", "dac1 masked", code_of(1), dbg ? lvl(v2) : b);

                // Set-VID strobe in the same cycle power-good falls
                sys_pgood = 1'b0;
                send_svid(3'b111, 100);
                chk(seq_state == 3'd5, "R8", "return state", seq_state, 5);
                wait_idle(cyc);
                chk_all("R9", "fall wins over set-VID", b);
                tick(3);
                chk(seq_state == (dbg ? 3'd6 : 3'd3), "R8", "after return", seq_state, dbg ? 6 : 3);

                // Strobe while disabled: not applied, not queued
                send_svid(3'b111, 100);
                tick(4);
                chk_all("R9", "discard while low", b);
                chk(slew_busy == 1'b0, "R9", "idle after discard", slew_busy, 0);

                // Re-enable serial
                sys_pgood = 1'b1;
                tick(1);
                chk(seq_state == 3'd4, "R6", "serial re-entry", seq_state, 4);
                chk_all("R9", "no queued word", b);
                send_svid(3'b010, b + 3);
                wait_idle(cyc);
                chk(cyc == 3 * DIV, "R7", "re-enabled slew", cyc, 3 * DIV);
                chk(code_of(1) == b + 3, "R7", "dac1 re-enabled", code_of(1), b + 3);
                chk(code_of(0) == b, "R7", "dac0 untouched", code_of(0), b);
                sys_pgood = 1'b0;
                tick(1);
                wait_idle(cyc);
                chk_all("R8", "second return", b);

                // Shutdown
                run_en = 1'b0; ref_ok = 1'b0;
                tick(1);
                chk(seq_state == 3'd0, "R1", "shutdown state", seq_state, 0);
                chk_all("R1", "shutdown code", 0);
                tick(2);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule